// File: doc/BRIEF.md
# Stop-Mode Standby Controller

This block sequences the deepest standby state of a small processor subsystem. Software first sets a stop-select bit and then writes a standby trigger. While the subsystem is running, that trigger takes the block into a stop state. In the stop state the core and peripheral clock enables are low and the oscillator enable is dropped. Register and memory contents are left untouched. Peripherals clocked from outside the subsystem do not depend on these enables, so they keep running.

Two kinds of event end the stop state. The first is a maskable interrupt that is not masked, from an external pin or from a peripheral that can run while stopped. The second is any reset source. After either event the oscillator restarts, and the clocks stay gated while a programmable stabilisation count runs down.

When the count expires the clocks return and the block decides how execution continues. It emits a one-cycle acknowledge, carrying the winning source's index, when the waking request outranks the handler in service, or when no handler is in service. Otherwise it emits a one-cycle resume pulse: the request stays pending in the interrupt controller and execution goes on at the instruction after the stop instruction. A wake by a reset source produces neither pulse.

Top module: `stby_stop_ctrl`

## Requirements
- R1: After `rst_ni` is released, `core_clk_en_o`, `per_clk_en_o` and `osc_en_o` are 1, `ack_irq_o` and `resume_next_o` are 0, and the stop-select bit is 0.
- R2: Configuration writes use three addresses. Address 0, bit 0 is stop-select. Address 1, bit 0 is the trigger and bit 1 is the global mask. Address 2 holds the stabilisation count N. A trigger write made while running with stop-select at 1 drops all three enables at the second rising edge after the write edge.
- R3: A trigger write made while stop-select is 0 has no effect, and the clocks stay on.
- R4: While stopped, with no reset source and no unmasked request, all enables stay low.
- R5: A request wakes the block when its bit is 1 and its mask bit is 0. Sources are numbered external 0..N_EXT-1, then peripheral N_EXT upward. A request whose mask bit is 1 does not wake the block.
- R6: With the global mask at 1, no interrupt request wakes the block; a reset source still does.
- R7: Counting from the wake edge, `osc_en_o` is 1 and both clock enables are 0 for N+1 cycles; the clock enables return at the (N+2)th edge.
- R8: The decision is taken from the request that wins, using `in_service_i` and `isr_prio_i` as sampled at the wake edge. A smaller priority value means a more urgent request. The block acknowledges when no handler is in service, or when the winner's value is strictly less than `isr_prio_i`; otherwise it emits a resume pulse.
- R9: When several requests wake the block together, the one with the smallest priority value wins, and a tie goes to the lowest index. `ack_id_o` holds the winner's index.
- R10: `ack_irq_o` and `resume_next_o` are high for exactly one cycle, in the cycle the clocks return, and never together.
- R11: A reset source (`rst_src_i` nonzero) while stopped or stabilising leads to the same stabilisation and then to running with no pulse. It wins over a request in the same cycle, and while running it cancels a pending trigger.
- R12: Configuration writes made while stopped or stabilising are ignored.
- R13: Once running again after a wake, the block stays running until a new trigger write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock from the restarting oscillator domain |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| rst_src_i | input | N_RST | Reset-source wake requests (pin, low-voltage, power-on) |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration address |
| cfg_wdata_i | input | STAB_W | Configuration write data |
| ext_irq_i | input | N_EXT | External interrupt requests |
| ext_mask_i | input | N_EXT | External request masks, 1 = masked |
| per_irq_i | input | N_PER | Stop-capable peripheral requests |
| per_mask_i | input | N_PER | Peripheral request masks, 1 = masked |
| src_prio_i | input | (N_EXT+N_PER)*PRIO_W | Priority of each source, packed by index |
| in_service_i | input | 1 | A handler is currently in service |
| isr_prio_i | input | PRIO_W | Priority of the handler in service |
| core_clk_en_o | output | 1 | Core clock enable |
| per_clk_en_o | output | 1 | On-chip peripheral clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| ack_irq_o | output | 1 | One-cycle acknowledge of the waking request |
| ack_id_o | output | $clog2(N_EXT+N_PER) | Index of the acknowledged source |
| resume_next_o | output | 1 | One-cycle resume-at-next-instruction pulse |

## Verification
Two events can fall in the same cycle: a reset-source wake and an interrupt wake in the stop state, and a reset source and a pending trigger in the running state. The bench produces the first by driving one unmasked request and one reset source on the same clock edge. It then requires the block to stabilise and return to running with neither pulse. For the second, it raises a reset source on the edge where the trigger would start the stop, then requires the clocks to stay on from then onward.

// File: rtl/stby_pkg.sv
package stby_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STOP = 2'd1,
        ST_STAB = 2'd2,
        ST_DONE = 2'd3
    } stby_state_e;

    localparam logic [1:0] CFG_MODE = 2'd0;
    localparam logic [1:0] CFG_CTRL = 2'd1;
    localparam logic [1:0] CFG_STAB = 2'd2;
endpackage

// File: rtl/stby_cfg_regs.sv
module stby_cfg_regs
    import stby_pkg::*;
#(
    parameter int STAB_W    = 8,
    parameter int STAB_INIT = 15
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [1:0]        addr_i,
    input  logic [STAB_W-1:0] wdata_i,
    input  logic              accept_i,
    input  logic              clr_trig_i,
    output logic              mode_o,
    output logic              trig_o,
    output logic              gmask_o,
    output logic [STAB_W-1:0] stab_o
);
    typedef struct packed {
        logic              mode;
        logic              trig;
        logic              gmask;
        logic [STAB_W-1:0] stab;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic wr_ok;

    always_comb begin
        cfg_d = cfg_q;
        wr_ok = we_i && accept_i;
        if (wr_ok && addr_i == CFG_MODE) begin
            cfg_d.mode = wdata_i[0];
        end
        if (wr_ok && addr_i == CFG_CTRL) begin
            cfg_d.gmask = wdata_i[1];
            cfg_d.trig  = wdata_i[0] && cfg_q.mode;
        end
        if (wr_ok && addr_i == CFG_STAB) begin
            cfg_d.stab = wdata_i;
        end
        if (clr_trig_i) begin
            cfg_d.trig = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '{mode: 1'b0, trig: 1'b0, gmask: 1'b0, stab: STAB_W'(STAB_INIT)};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode_o  = cfg_q.mode;
    assign trig_o  = cfg_q.trig;
    assign gmask_o = cfg_q.gmask;
    assign stab_o  = cfg_q.stab;
endmodule

// File: rtl/stby_wake_arb.sv
module stby_wake_arb #(
    parameter int NSRC   = 6,
    parameter int PRIO_W = 3,
    parameter int IDW    = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]        irq_i,
    input  logic [NSRC-1:0]        mask_i,
    input  logic                   gmask_i,
    input  logic [NSRC*PRIO_W-1:0] prio_i,
    output logic                   any_o,
    output logic [IDW-1:0]         id_o,
    output logic [PRIO_W-1:0]      prio_o
);
    logic [NSRC-1:0] req;

    always_comb begin
        req    = irq_i & ~mask_i & {NSRC{~gmask_i}};
        any_o  = 1'b0;
        id_o   = '0;
        prio_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (req[i] && (!any_o || prio_i[i*PRIO_W +: PRIO_W] < prio_o)) begin
                any_o  = 1'b1;
                id_o   = IDW'(i);
                prio_o = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/stby_stab_cnt.sv
module stby_stab_cnt #(
    parameter int STAB_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [STAB_W-1:0] load_val_i,
    input  logic              run_i,
    output logic              zero_o
);
    logic [STAB_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (run_i && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/stby_stop_ctrl.sv
module stby_stop_ctrl
    import stby_pkg::*;
#(
    parameter int N_EXT     = 4,
    parameter int N_PER     = 2,
    parameter int N_RST     = 3,
    parameter int PRIO_W    = 3,
    parameter int STAB_W    = 8,
    parameter int STAB_INIT = 15,
    localparam int NSRC     = N_EXT + N_PER,
    localparam int IDW      = $clog2(NSRC)
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [N_RST-1:0]       rst_src_i,
    input  logic                   cfg_we_i,
    input  logic [1:0]             cfg_addr_i,
    input  logic [STAB_W-1:0]      cfg_wdata_i,
    input  logic [N_EXT-1:0]       ext_irq_i,
    input  logic [N_EXT-1:0]       ext_mask_i,
    input  logic [N_PER-1:0]       per_irq_i,
    input  logic [N_PER-1:0]       per_mask_i,
    input  logic [NSRC*PRIO_W-1:0] src_prio_i,
    input  logic                   in_service_i,
    input  logic [PRIO_W-1:0]      isr_prio_i,
    output logic                   core_clk_en_o,
    output logic                   per_clk_en_o,
    output logic                   osc_en_o,
    output logic                   ack_irq_o,
    output logic [IDW-1:0]         ack_id_o,
    output logic                   resume_next_o
);
    typedef struct packed {
        stby_state_e    state;
        logic           from_rst;
        logic           ack_pend;
        logic [IDW-1:0] id;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic              mode, trig, gmask;
    logic [STAB_W-1:0] stab_val;
    logic              wake_any;
    logic [IDW-1:0]    wake_id;
    logic [PRIO_W-1:0] wake_prio;
    logic              rst_any, clr_trig, cnt_load, cnt_run, cnt_zero;

    assign rst_any  = |rst_src_i;
    assign clr_trig = rst_any || (fsm_q.state == ST_RUN && trig && mode);
    assign cnt_load = (fsm_q.state == ST_STOP) && (rst_any || wake_any);
    assign cnt_run  = (fsm_q.state == ST_STAB);

    stby_cfg_regs #(.STAB_W(STAB_W), .STAB_INIT(STAB_INIT)) cfg_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .we_i       (cfg_we_i),
        .addr_i     (cfg_addr_i),
        .wdata_i    (cfg_wdata_i),
        .accept_i   (fsm_q.state == ST_RUN),
        .clr_trig_i (clr_trig),
        .mode_o     (mode),
        .trig_o     (trig),
        .gmask_o    (gmask),
        .stab_o     (stab_val)
    );

    stby_wake_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDW(IDW)) arb_i (
        .irq_i   ({per_irq_i, ext_irq_i}),
        .mask_i  ({per_mask_i, ext_mask_i}),
        .gmask_i (gmask),
        .prio_i  (src_prio_i),
        .any_o   (wake_any),
        .id_o    (wake_id),
        .prio_o  (wake_prio)
    );

    stby_stab_cnt #(.STAB_W(STAB_W)) cnt_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (cnt_load),
        .load_val_i (stab_val),
        .run_i      (cnt_run),
        .zero_o     (cnt_zero)
    );

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.state)
            ST_RUN: begin
                if (trig && mode && !rst_any) begin
                    fsm_d.state = ST_STOP;
                end
            end
            ST_STOP: begin
                if (rst_any) begin
                    fsm_d.state    = ST_STAB;
                    fsm_d.from_rst = 1'b1;
                    fsm_d.ack_pend = 1'b0;
                end else if (wake_any) begin
                    fsm_d.state    = ST_STAB;
                    fsm_d.from_rst = 1'b0;
                    fsm_d.id       = wake_id;
                    fsm_d.ack_pend = !in_service_i || (wake_prio < isr_prio_i);
                end
            end
            ST_STAB: begin
                if (rst_any) begin
                    fsm_d.from_rst = 1'b1;
                end
                if (cnt_zero) begin
                    fsm_d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                fsm_d.state    = ST_RUN;
                fsm_d.from_rst = 1'b0;
            end
            default: fsm_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fsm_q <= '{state: ST_RUN, from_rst: 1'b0, ack_pend: 1'b0, id: '0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign core_clk_en_o = (fsm_q.state == ST_RUN) || (fsm_q.state == ST_DONE);
    assign per_clk_en_o  = core_clk_en_o;
    assign osc_en_o      = (fsm_q.state != ST_STOP);
    assign ack_irq_o     = (fsm_q.state == ST_DONE) && !fsm_q.from_rst && fsm_q.ack_pend;
    assign resume_next_o = (fsm_q.state == ST_DONE) && !fsm_q.from_rst && !fsm_q.ack_pend;
    assign ack_id_o      = fsm_q.id;
endmodule

// File: rtl/stby_stop_chk.sv
module stby_stop_chk #(
    parameter int N_EXT = 4,
    parameter int N_PER = 2,
    parameter int N_RST = 3
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [N_RST-1:0] rst_src_i,
    input logic [N_EXT-1:0] ext_irq_i,
    input logic [N_EXT-1:0] ext_mask_i,
    input logic [N_PER-1:0] per_irq_i,
    input logic [N_PER-1:0] per_mask_i,
    input logic             core_clk_en_o,
    input logic             per_clk_en_o,
    input logic             osc_en_o,
    input logic             ack_irq_o,
    input logic             resume_next_o
);
    logic open_req;
    assign open_req = |(ext_irq_i & ~ext_mask_i) || |(per_irq_i & ~per_mask_i);

    // R10
    pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ack_irq_o && resume_next_o));

    // R10
    pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_irq_o || resume_next_o) |=> !(ack_irq_o || resume_next_o));

    // R7
    pulse_after_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_irq_o || resume_next_o) |-> ($past(!core_clk_en_o) && core_clk_en_o));

    // R7
    osc_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !osc_en_o |-> (!core_clk_en_o && !per_clk_en_o));

    // R4
    stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!osc_en_o && rst_src_i == '0 && !open_req) |=> !osc_en_o);

    // R11
    rst_no_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_src_i != '0 && !core_clk_en_o) |=> !(ack_irq_o || resume_next_o));
endmodule

bind stby_stop_ctrl stby_stop_chk #(.N_EXT(N_EXT), .N_PER(N_PER), .N_RST(N_RST)) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rst_src_i     (rst_src_i),
    .ext_irq_i     (ext_irq_i),
    .ext_mask_i    (ext_mask_i),
    .per_irq_i     (per_irq_i),
    .per_mask_i    (per_mask_i),
    .core_clk_en_o (core_clk_en_o),
    .per_clk_en_o  (per_clk_en_o),
    .osc_en_o      (osc_en_o),
    .ack_irq_o     (ack_irq_o),
    .resume_next_o (resume_next_o)
);

// File: tb/stby_stop_ctrl_tb.sv
module stby_stop_ctrl_tb_top;
    localparam int N_EXT = 4, N_PER = 2, N_RST = 3, PW = 3, SW = 8;
    localparam int NSRC = N_EXT + N_PER;
    localparam int IDW = $clog2(NSRC);

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N_RST-1:0] rst_src = '0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [SW-1:0] cfg_wdata = '0;
    logic [N_EXT-1:0] ext_irq = '0, ext_mask = '0;
    logic [N_PER-1:0] per_irq = '0, per_mask = '0;
    logic [NSRC*PW-1:0] prio = '0;
    logic in_svc = 1'b0;
    logic [PW-1:0] isr_prio = '0;
    logic core_en, per_en, osc_en, ack, res;
    logic [IDW-1:0] ack_id;

    int errors = 0, checks = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    stby_stop_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .rst_src_i(rst_src),
        .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
        .ext_irq_i(ext_irq), .ext_mask_i(ext_mask),
        .per_irq_i(per_irq), .per_mask_i(per_mask),
        .src_prio_i(prio), .in_service_i(in_svc), .isr_prio_i(isr_prio),
        .core_clk_en_o(core_en), .per_clk_en_o(per_en), .osc_en_o(osc_en),
        .ack_irq_o(ack), .ack_id_o(ack_id), .resume_next_o(res)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int outs();
        return {27'd0, core_en, per_en, osc_en, ack, res};
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [SW-1:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic set_irq(input int idx, input bit v);
        if (idx < N_EXT) ext_irq[idx] = v;
        else per_irq[idx-N_EXT] = v;
    endtask

    // trigger write, then one more edge: stopped (R2)
    task automatic enter(input bit gm, input string tag);
        wr(2'd1, {6'd0, gm, 1'b1});
        tick();
        chk(outs() == 0, tag, outs(), 0);
    endtask

    // wake edge is the next posedge; kind 0 none, 1 ack, 2 resume
    task automatic wake_seq(input int n, input int kind, input int eid, input string tag);
        for (int k = 1; k <= n + 3; k++) begin
            tick();
            if (k <= n + 1)
                chk(outs() == 5'b00100, {tag, " R7 gated"}, outs(), 5'b00100);
            else if (k == n + 2) begin
                int e;
                e = {kind == 1, kind == 2} | 5'b11100;
                chk(outs() == e, {tag, " R10 pulse"}, outs(), e);
                if (kind == 1) chk(ack_id == IDW'(eid), {tag, " R9 id"}, ack_id, eid);
            end else
                chk(outs() == 5'b11100, {tag, " R13 run"}, outs(), 5'b11100);
        end
        ext_irq = '0; per_irq = '0; rst_src = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk(outs() == 5'b11100, "R1 reset outputs", outs(), 5'b11100);

        // R3: stop-select still 0
        wr(2'd1, 8'd1);
        repeat (3) tick();
        chk(outs() == 5'b11100, "R3 trigger ignored", outs(), 5'b11100);
        wr(2'd0, 8'd1);

        // R7/R5/R4 sweep over count and source, no handler in service
        for (int n = 0; n < 6; n++)
            for (int s = 0; s < NSRC; s++) begin
                wr(2'd2, SW'(n));
                enter(1'b0, "R2 enter");
                repeat (2) tick();
                chk(outs() == 0, "R4 hold", outs(), 0);
                set_irq(s, 1'b1);
                wake_seq(n, 1, s, "R5 wake");
            end

        // R8 priority sweep, handler in service
        wr(2'd2, 8'd1);
        in_svc = 1'b1;
        for (int p = 0; p < 8; p++)
            for (int q = 0; q < 8; q++) begin
                prio[2*PW +: PW] = PW'(p);
                isr_prio = PW'(q);
                enter(1'b0, "R2 enter");
                set_irq(2, 1'b1);
                wake_seq(1, (p < q) ? 1 : 2, 2, "R8 compare");
            end
        in_svc = 1'b0;

        // R9 every request pattern, with ties
        prio = {3'd1, 3'd4, 3'd1, 3'd2, 3'd4, 3'd2};
        wr(2'd2, 8'd0);
        for (int pat = 1; pat < (1 << NSRC); pat++) begin
            int best, bp;
            best = 0; bp = 8;
            for (int i = 0; i < NSRC; i++)
                if (pat[i] && int'(prio[i*PW +: PW]) < bp) begin
                    bp = int'(prio[i*PW +: PW]); best = i;
                end
            enter(1'b0, "R2 enter");
            ext_irq = pat[N_EXT-1:0];
            per_irq = pat[NSRC-1:N_EXT];
            wake_seq(0, 1, best, "R9 select");
        end

        // R5 masked request ignored, then unmasked
        enter(1'b0, "R2 enter");
        ext_mask[1] = 1'b1; ext_irq[1] = 1'b1;
        repeat (4) tick();
        chk(outs() == 0, "R5 masked ignored", outs(), 0);
        ext_mask[1] = 1'b0;
        wake_seq(0, 1, 1, "R5 unmasked");

        // R6 global mask, then reset-source wake (R11)
        enter(1'b1, "R2 enter");
        per_irq = '1;
        repeat (4) tick();
        chk(outs() == 0, "R6 gmask blocks", outs(), 0);
        rst_src = 3'b100;
        wake_seq(0, 0, 0, "R11 rst wake");
        wr(2'd1, 8'd0);

        // R11 reset and request in the same cycle
        wr(2'd2, 8'd2);
        enter(1'b0, "R2 enter");
        ext_irq[0] = 1'b1; rst_src = 3'b001;
        wake_seq(2, 0, 0, "R11 same cycle");

        // R11 reset source cancels pending trigger
        wr(2'd1, 8'd1);
        rst_src = 3'b010;
        tick();
        rst_src = '0;
        repeat (3) tick();
        chk(outs() == 5'b11100, "R11 trigger cleared", outs(), 5'b11100);

        // R12 write while stopped ignored (count stays 2)
        enter(1'b0, "R2 enter");
        wr(2'd2, 8'd9);
        chk(outs() == 0, "R12 still stopped", outs(), 0);
        set_irq(5, 1'b1);
        wake_seq(2, 1, 5, "R12 write ignored");

        // R13 stays running
        repeat (5) tick();
        chk(outs() == 5'b11100, "R13 no re-entry", outs(), 5'b11100);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule